// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block arbitrates eight interrupt request lines onto a single interrupt output toward a processor. Software configures it through a small register port: one address bit, write and read strobes, and an 8-bit data bus. Before it will raise an interrupt, software must send a short sequence of configuration words. That sequence sets the vector base, the cascade description and the end-of-interrupt mode. Once the sequence is complete, odd-address writes load the mask, and even-address writes carry commands. The commands select what an even-address read returns and clear individual in-service bits.

The processor answers an interrupt with a one-cycle acknowledge pulse. While that pulse is high, the block presents the vector number: the programmed base plus the level of the winning request. Line 0 has the highest priority. A request wins only if no line of equal or higher priority is in service. Each line can be set independently to edge or level sensing through a trigger word, written with its own strobe. Sometimes a request disappears before it is acknowledged. The acknowledge then returns the level-7 vector and changes nothing, which lets software recognise a spurious interrupt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: An even-address write with data bit 4 set starts configuration. The odd-address writes that follow are taken in this order: the vector base; then the cascade word, skipped when bit 1 of the starting word is set; then the mode word, present only when bit 0 of the starting word is set. Until the last word is written, `irq_out` stays low and odd writes do not load the mask.
- R2: While `ack` is high, `ack_vector` equals (base + level) modulo 256, where level is the 3-bit index of the winning line.
- R3: The cascade word is stored unchanged and shown on `cascade_cfg`. A sequence that skips the cascade word leaves the stored value as it was.
- R4: Bit 1 of the mode word selects auto end-of-interrupt. In that mode an acknowledge never leaves an in-service bit set.
- R5: After configuration, an odd-address write loads the mask. A mask bit of 1 stops that line from raising `irq_out`. An odd-address read returns the mask.
- R6: An even-address command with bits 4 and 3 equal to 0 and 1 and bit 1 set chooses the source for later even-address reads. Bit 0 equal to 0 (0x0A) selects the request register, and bit 0 equal to 1 (0x0B) selects the in-service register. The choice holds until it is rewritten.
- R7: An even-address command whose bits 7..5 are 011 and whose bits 4..3 are 00 clears only the in-service bit named by bits 2..0 (0x60 plus level).
- R8: A pulse on `trig_wr` loads the trigger word from `wdata`, where bit i = 1 means level sensing and 0 means edge sensing; the reset value is all edge. A level line's request bit follows its input, one cycle later. An edge line's request bit is set by a 0-to-1 transition. It stays set while the input is high, and clears when the input falls or when the line is acknowledged; after that, a new rising transition is needed.
- R9: Line 0 has the highest priority. `irq_out` is high exactly when configuration is complete and some unmasked request has a strictly higher priority than every in-service level.
- R10: An acknowledge that arrives while there is no winning request returns base + 7 and leaves the in-service register unchanged. This holds even when line 7 is masked.
- R11: Starting configuration clears the mask, the in-service register and the auto end-of-interrupt bit, and selects the request register for reads. The trigger word is kept.
- R12: In normal mode, an acknowledge with a winner sets that line's in-service bit. In either mode, the acknowledge clears that line's edge-captured request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register address bit (0 even, 1 odd) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is zero when low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| trig_wr | input | 1 | Loads the per-line trigger word from `wdata` |
| irq_in | input | 8 | Interrupt request lines |
| irq_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | One-cycle interrupt acknowledge |
| ack_vector | output | 8 | Vector number, valid while `ack` is high |
| cascade_cfg | output | 8 | Stored cascade word |

## Verification
A stale in-service bit shows up at `irq_out` in the same cycle: lower-priority requests stay silent, or an equal-level request fires again. A read with the in-service source selected exposes the bit directly. A wrong request-register update appears one cycle after the input changes, either in the request readback or as a wrong `ack_vector`. A configuration sequencer in the wrong state is caught at the next odd write: a word lands in the base, the cascade or the mask register when it should have gone to another. Because the reference model is compared on every clock, each such divergence is reported in the first cycle it becomes visible.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int IRQ_N  = 8;
  localparam int LVL_W  = $clog2(IRQ_N);
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BASE  = 3'd1,
    ST_CASC  = 3'd2,
    ST_MODE  = 3'd3,
    ST_READY = 3'd4
  } cfg_state_e;

  // Lowest set index wins; MSB of result flags that any bit was set.
  function automatic logic [LVL_W:0] first_set(input logic [IRQ_N-1:0] v);
    logic [LVL_W:0] r;
    r = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, LVL_W'(i)};
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] vec_of(input logic [DATA_W-1:0] base,
                                               input logic [LVL_W-1:0] lvl);
    return base + DATA_W'(lvl);
  endfunction

  function automatic logic is_start_cmd(input logic [DATA_W-1:0] d);
    return d[4];
  endfunction

  function automatic logic is_rdsel_cmd(input logic [DATA_W-1:0] d);
    return !d[4] && d[3] && d[1];
  endfunction

  function automatic logic is_seoi_cmd(input logic [DATA_W-1:0] d);
    return (d[7:5] == 3'b011) && (d[4:3] == 2'b00);
  endfunction

  function automatic cfg_state_e after_base(input logic single, input logic want_mode);
    if (!single)   return ST_CASC;
    if (want_mode) return ST_MODE;
    return ST_READY;
  endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              trig_wr,
  output logic              ready,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] casc,
  output logic              aeoi,
  output logic [IRQ_N-1:0]  mask,
  output logic [IRQ_N-1:0]  trig,
  output logic              rd_isr,
  output logic              init_start,
  output logic              eoi_hit,
  output logic [LVL_W-1:0]  eoi_lvl
);
  cfg_state_e state;
  logic       want_mode;
  logic       single;
  logic       wr_even;
  logic       wr_odd;
  logic       rdsel_hit;

  assign wr_even    = wr_en && !reg_sel;
  assign wr_odd     = wr_en && reg_sel;
  assign ready      = (state == ST_READY);
  assign init_start = wr_even && is_start_cmd(wdata);
  assign eoi_hit    = wr_even && ready && is_seoi_cmd(wdata);
  assign eoi_lvl    = wdata[LVL_W-1:0];
  assign rdsel_hit  = wr_even && ready && is_rdsel_cmd(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      want_mode <= 1'b0;
      single    <= 1'b0;
      base      <= '0;
      casc      <= '0;
      aeoi      <= 1'b0;
      mask      <= '0;
      trig      <= '0;
      rd_isr    <= 1'b0;
    end else begin
      if (trig_wr) trig <= wdata[IRQ_N-1:0];
      if (init_start) begin
        state     <= ST_BASE;
        want_mode <= wdata[0];
        single    <= wdata[1];
        mask      <= '0;
        aeoi      <= 1'b0;
        rd_isr    <= 1'b0;
      end else if (wr_odd) begin
        case (state)
          ST_BASE: begin
            base  <= wdata;
            state <= after_base(single, want_mode);
          end
          ST_CASC: begin
            casc  <= wdata;
            state <= want_mode ? ST_MODE : ST_READY;
          end
          ST_MODE: begin
            aeoi  <= wdata[1];
            state <= ST_READY;
          end
          ST_READY: mask <= wdata[IRQ_N-1:0];
          default: ;
        endcase
      end else if (rdsel_hit) begin
        rd_isr <= wdata[0];
      end
    end
  end
endmodule

// File: rtl/pic_req.sv
module pic_req
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] irq_in,
  input  logic [IRQ_N-1:0] trig,
  input  logic [IRQ_N-1:0] take_hot,
  output logic [IRQ_N-1:0] pending
);
  logic [IRQ_N-1:0] prev_in;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_line
    logic nxt;
    always_comb begin
      if (trig[g]) nxt = irq_in[g];
      else         nxt = irq_in[g] && (!prev_in[g] || pending[g]) && !take_hot[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[g] <= 1'b0;
        prev_in[g] <= 1'b0;
      end else begin
        pending[g] <= nxt;
        prev_in[g] <= irq_in[g];
      end
    end
  end
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
  import pic_pkg::*;
(
  input  logic             ready,
  input  logic [IRQ_N-1:0] pending,
  input  logic [IRQ_N-1:0] mask,
  input  logic [IRQ_N-1:0] isr,
  output logic             win_valid,
  output logic [LVL_W-1:0] win_lvl
);
  logic [LVL_W:0] req_pick;
  logic [LVL_W:0] svc_pick;

  assign req_pick  = first_set(pending & ~mask);
  assign svc_pick  = first_set(isr);
  assign win_lvl   = req_pick[LVL_W-1:0];
  assign win_valid = ready && req_pick[LVL_W] &&
                     (!svc_pick[LVL_W] || (req_pick[LVL_W-1:0] < svc_pick[LVL_W-1:0]));
endmodule

// File: rtl/pic_isr.sv
module pic_isr
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_start,
  input  logic             set_en,
  input  logic [LVL_W-1:0] set_lvl,
  input  logic             eoi_hit,
  input  logic [LVL_W-1:0] eoi_lvl,
  output logic [IRQ_N-1:0] isr
);
  logic [IRQ_N-1:0] set_hot;
  logic [IRQ_N-1:0] clr_hot;

  assign set_hot = set_en  ? (IRQ_N'(1) << set_lvl) : '0;
  assign clr_hot = eoi_hit ? (IRQ_N'(1) << eoi_lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          isr <= '0;
    else if (init_start) isr <= '0;
    else                 isr <= (isr | set_hot) & ~clr_hot;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              trig_wr,
  input  logic [IRQ_N-1:0]  irq_in,
  output logic              irq_out,
  input  logic              ack,
  output logic [DATA_W-1:0] ack_vector,
  output logic [DATA_W-1:0] cascade_cfg
);
  logic              ready;
  logic [DATA_W-1:0] base;
  logic              aeoi;
  logic [IRQ_N-1:0]  mask;
  logic [IRQ_N-1:0]  trig;
  logic              rd_isr;
  logic              init_start;
  logic              eoi_hit;
  logic [LVL_W-1:0]  eoi_lvl;
  logic [IRQ_N-1:0]  pending;
  logic [IRQ_N-1:0]  isr;
  logic              win_valid;
  logic [LVL_W-1:0]  win_lvl;
  logic              take;
  logic [IRQ_N-1:0]  take_hot;
  logic [DATA_W-1:0] rd_mux;

  pic_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wdata(wdata),
    .trig_wr(trig_wr), .ready(ready), .base(base), .casc(cascade_cfg), .aeoi(aeoi),
    .mask(mask), .trig(trig), .rd_isr(rd_isr), .init_start(init_start),
    .eoi_hit(eoi_hit), .eoi_lvl(eoi_lvl)
  );

  pic_req u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig(trig),
    .take_hot(take_hot), .pending(pending)
  );

  pic_resolve u_res (
    .ready(ready), .pending(pending), .mask(mask), .isr(isr),
    .win_valid(win_valid), .win_lvl(win_lvl)
  );

  assign take     = ack && win_valid;
  assign take_hot = take ? (IRQ_N'(1) << win_lvl) : '0;

  pic_isr u_isr (
    .clk(clk), .rst_n(rst_n), .init_start(init_start),
    .set_en(take && !aeoi), .set_lvl(win_lvl),
    .eoi_hit(eoi_hit), .eoi_lvl(eoi_lvl), .isr(isr)
  );

  assign irq_out    = win_valid;
  assign ack_vector = vec_of(base, win_valid ? win_lvl : LVL_W'(IRQ_N - 1));

  always_comb begin
    if (reg_sel)     rd_mux = DATA_W'(mask);
    else if (rd_isr) rd_mux = DATA_W'(isr);
    else             rd_mux = DATA_W'(pending);
  end
  assign rdata = rd_en ? rd_mux : '0;
endmodule

// File: rtl/pic_checks.sv
module pic_checks
  import pic_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             irq_out,
  input logic             ack,
  input logic             aeoi,
  input logic             win_valid,
  input logic             init_start,
  input logic             eoi_hit,
  input logic [LVL_W-1:0] eoi_lvl,
  input logic [IRQ_N-1:0] pending,
  input logic [IRQ_N-1:0] mask,
  input logic [IRQ_N-1:0] isr
);
  AST_NO_IRQ_UNCONFIGURED: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !irq_out); // R1

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((pending & ~mask) != '0)); // R5

  AST_SPURIOUS_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !win_valid && !init_start && !eoi_hit) |=> (isr == $past(isr))); // R10

  AST_AUTO_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    aeoi |-> (isr == '0)); // R4

  AST_SEOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !ack && !init_start) |=> !isr[$past(eoi_lvl)]); // R7

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> ((mask == '0) && (isr == '0))); // R11
endmodule

bind prio_irq_ctrl pic_checks u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .irq_out(irq_out), .ack(ack),
  .aeoi(aeoi), .win_valid(win_valid), .init_start(init_start), .eoi_hit(eoi_hit),
  .eoi_lvl(eoi_lvl), .pending(pending), .mask(mask), .isr(isr)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, trig_wr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'h00, irq_in = 8'h00;
  logic [7:0] rdata, ack_vector, cascade_cfg;
  logic       irq_out;
  int         checks = 0, errors = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .trig_wr(trig_wr), .irq_in(irq_in),
    .irq_out(irq_out), .ack(ack), .ack_vector(ack_vector), .cascade_cfg(cascade_cfg)
  );

  // Behavioural reference model: stage 0 idle, 1 base, 2 cascade, 3 mode, 4 running.
  int         m_stage = 0;
  bit         m_mode_word = 0, m_single = 0, m_aeoi = 0, m_sel_isr = 0;
  logic [7:0] m_base = 0, m_casc = 0, m_mask = 0, m_trig = 0, m_req = 0, m_svc = 0, m_prev = 0;

  function automatic int m_winner();
    int r = -1, s = 8;
    for (int i = 7; i >= 0; i--) if (m_req[i] && !m_mask[i]) r = i;
    for (int i = 7; i >= 0; i--) if (m_svc[i]) s = i;
    if (m_stage != 4 || r < 0 || r >= s) return -1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_aeoi = 0; m_sel_isr = 0; m_base = 0; m_casc = 0;
      m_mask = 0; m_trig = 0; m_req = 0; m_svc = 0; m_prev = 0;
    end else begin
      int w;
      logic [7:0] nreq, nsvc;
      w = m_winner();
      nsvc = m_svc;
      if (ack && w >= 0 && !m_aeoi) nsvc[w] = 1'b1;
      for (int i = 0; i < 8; i++) begin
        if (m_trig[i]) nreq[i] = irq_in[i];
        else nreq[i] = irq_in[i] && (!m_prev[i] || m_req[i]) && !(ack && w == i);
      end
      if (wr_en && !reg_sel && m_stage == 4 && wdata[7:3] == 5'b01100) nsvc[wdata[2:0]] = 1'b0;
      if (trig_wr) m_trig = wdata;
      if (wr_en && !reg_sel && wdata[4]) begin
        m_stage = 1; m_mode_word = wdata[0]; m_single = wdata[1];
        m_mask = 0; m_aeoi = 0; m_sel_isr = 0; nsvc = 0;
      end else if (wr_en && reg_sel) begin
        if (m_stage == 1) begin
          m_base = wdata;
          m_stage = !m_single ? 2 : (m_mode_word ? 3 : 4);
        end else if (m_stage == 2) begin
          m_casc = wdata; m_stage = m_mode_word ? 3 : 4;
        end else if (m_stage == 3) begin
          m_aeoi = wdata[1]; m_stage = 4;
        end else if (m_stage == 4) m_mask = wdata;
      end else if (wr_en && !reg_sel && m_stage == 4 && !wdata[4] && wdata[3] && wdata[1])
        m_sel_isr = wdata[0];
      m_prev = irq_in;
      m_req = nreq;
      m_svc = nsvc;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge.
  always @(negedge clk) begin
    if (rst_n) begin
      int w;
      w = m_winner();
      chk("R9 irq_out", {7'd0, irq_out}, {7'd0, w >= 0});
      chk("R2 vector", ack_vector, m_base + 8'(w >= 0 ? w : 7));
      chk("R3 cascade", cascade_cfg, m_casc);
      if (rd_en) chk("R6 rdata", rdata, reg_sel ? m_mask : (m_sel_isr ? m_svc : m_req));
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #1; reg_sel = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask
  task automatic rd(input logic a, output logic [7:0] d);
    @(posedge clk); #1; reg_sel = a; rd_en = 1'b1;
    @(negedge clk); d = rdata;
    @(posedge clk); #1; rd_en = 1'b0;
  endtask
  task automatic do_ack(output logic [7:0] d);
    @(posedge clk); #1; ack = 1'b1;
    @(negedge clk); d = ack_vector;
    @(posedge clk); #1; ack = 1'b0;
  endtask
  task automatic set_in(input logic [7:0] d);
    @(posedge clk); #1; irq_in = d;
    @(posedge clk); #1;
  endtask
  task automatic look_irq(input string tag, input logic exp);
    @(negedge clk); chk(tag, {7'd0, irq_out}, {7'd0, exp});
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(1'b0, v); chk("R11 reset request readback", v, 8'h00);
    rd(1'b1, v); chk("R5 reset mask", v, 8'h00);
    set_in(8'h08);
    look_irq("R1 no irq before configuration", 1'b0);
    wr(1'b0, 8'h11); wr(1'b1, 8'h20);
    wr(1'b1, 8'h07);
    look_irq("R1 irq held low mid-sequence", 1'b0);
    wr(1'b1, 8'h01);
    @(negedge clk); chk("R3 cascade stored", cascade_cfg, 8'h07);
    look_irq("R9 line 3 raises irq", 1'b1);
    do_ack(v); chk("R2 vector base+3", v, 8'h23);
    look_irq("R12 edge request consumed", 1'b0);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R12 isr bit 3 set", v, 8'h08);
    set_in(8'h28);
    look_irq("R9 lower line blocked by service", 1'b0);
    set_in(8'h2A);
    look_irq("R9 higher line preempts", 1'b1);
    do_ack(v); chk("R2 vector base+1", v, 8'h21);
    rd(1'b0, v); chk("R6 isr selection held", v, 8'h0A);
    wr(1'b0, 8'h61);
    rd(1'b0, v); chk("R7 specific eoi clears only level 1", v, 8'h08);
    wr(1'b0, 8'h63);
    look_irq("R9 line 5 released", 1'b1);
    wr(1'b1, 8'h20);
    look_irq("R5 mask blocks line 5", 1'b0);
    rd(1'b1, v); chk("R5 mask readback", v, 8'h20);
    wr(1'b1, 8'h00);
    look_irq("R5 unmask restores", 1'b1);
    set_in(8'h0A);
    look_irq("R8 edge request dropped with input", 1'b0);
    do_ack(v); chk("R10 spurious vector", v, 8'h27);
    rd(1'b0, v); chk("R10 isr untouched", v, 8'h00);
    wr(1'b1, 8'h80);
    do_ack(v); chk("R10 spurious with line 7 masked", v, 8'h27);
    wr(1'b1, 8'h00);
    @(posedge clk); #1; trig_wr = 1'b1; wdata = 8'h40;
    @(posedge clk); #1; trig_wr = 1'b0;
    set_in(8'h4A);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); chk("R8 level request visible", v, 8'h40);
    do_ack(v); chk("R2 vector base+6", v, 8'h26);
    look_irq("R9 equal level in service blocks", 1'b0);
    set_in(8'h0A);
    rd(1'b0, v); chk("R8 level request follows input", v, 8'h00);
    wr(1'b0, 8'h66);
    look_irq("R8 held edge inputs need new edge", 1'b0);
    set_in(8'h0E);
    do_ack(v); chk("R2 vector base+2", v, 8'h22);
    wr(1'b0, 8'h0B);
    set_in(8'h4E);
    look_irq("R9 level 6 below service 2", 1'b0);
    wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h03);
    @(negedge clk); chk("R3 skipped cascade keeps value", cascade_cfg, 8'h07);
    rd(1'b0, v); chk("R11 readback reset to requests", v, 8'h40);
    rd(1'b1, v); chk("R11 mask cleared", v, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R11 isr cleared", v, 8'h00);
    do_ack(v); chk("R2 vector new base+6", v, 8'h46);
    rd(1'b0, v); chk("R4 auto eoi leaves isr empty", v, 8'h00);
    look_irq("R4 level line fires again", 1'b1);
    set_in(8'h00);
    wr(1'b0, 8'h10); wr(1'b1, 8'h80);
    wr(1'b1, 8'h01);
    @(negedge clk); chk("R3 new cascade word", cascade_cfg, 8'h01);
    wr(1'b1, 8'hFF);
    rd(1'b1, v); chk("R1 short sequence then mask", v, 8'hFF);
    repeat (3) @(posedge clk);
    summary();
  end
endmodule